// File: doc/BRIEF.md
# Three-Wire Mode-Addressed Control Register

This block receives configuration through three slow wires: a data line, a shift clock and a latch strobe. A host shifts a 24-bit frame into the block, one bit for each rising edge of the shift clock, with the first frame bit sent first. It then pulses the latch line. The two leading bits of the frame form a mode code. When the latch arrives, that code picks which of three holding registers takes the remaining 22 payload bits: the gain register, the primary-system register or the secondary-system register. The fourth code is reserved for test use and is refused.

All three wires are oversampled in the system clock domain through two-flop synchronisers. When a frame is accepted, the block pulses a one-cycle update strobe for the register it wrote. When the latch arrives after the wrong number of shift edges, the frame is dropped and an error flag pulses for one cycle. The block also brings out the primary master-clock ratio select. This is the first payload bit of the secondary-system register, and it resets to the 256x setting.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, all three words are zero, `mclk_ratio_512` is 0 (256x), and no strobe or error pulse is active.
- R2: One bit is sampled per rising edge of `cfg_shift`. The first bit shifted is frame bit 1, and the mode code is {bit 1, bit 2}. The payload is frame bits 3 to 24, and frame bit 3 lands in word bit 21.
- R3: Mode code 2'b00 with exactly 24 shift edges loads the payload into `gain_word` and pulses `upd_gain` for one cycle.
- R4: Mode code 2'b01 with exactly 24 shift edges loads the payload into `prim_word` and pulses `upd_prim` for one cycle.
- R5: Mode code 2'b10 with exactly 24 shift edges loads the payload into `sec_word` and pulses `upd_sec` for one cycle.
- R6: Mode code 2'b11 (test) changes no word and raises no strobe and no error.
- R7: `mclk_ratio_512` equals frame bit 3 of the last accepted secondary frame (1 = 512x, 0 = 256x). It changes only together with `upd_sec`.
- R8: A latch after any shift count other than 24 (including zero) changes no word and pulses `frame_err` for one cycle.
- R9: At most one of `upd_gain`, `upd_prim`, `upd_sec` and `frame_err` is high in any cycle, and each stays high for a single cycle.
- R10: The commit happens on the rising edge of `cfg_latch`, and the bit count restarts after every latch. A correct frame that follows a rejected frame is therefore accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_data | input | 1 | Serial frame data |
| cfg_shift | input | 1 | Shift clock; data is taken on its rising edge |
| cfg_latch | input | 1 | Latch strobe; a rising edge commits the frame |
| gain_word | output | 22 | Gain holding register |
| prim_word | output | 22 | Primary-system holding register |
| sec_word | output | 22 | Secondary-system holding register |
| upd_gain | output | 1 | One-cycle pulse when the gain register is written |
| upd_prim | output | 1 | One-cycle pulse when the primary register is written |
| upd_sec | output | 1 | One-cycle pulse when the secondary register is written |
| frame_err | output | 1 | One-cycle pulse when a frame has the wrong length |
| mclk_ratio_512 | output | 1 | Primary master-clock ratio select, 1 = 512x |

## Verification
The assertions check on every cycle that the strobes and the error flag are mutually exclusive and last a single cycle. They also check that each word and the ratio select move only in the cycle of their own strobe, and that a length error leaves every word untouched. The bench scenarios are needed for the rest: the bit order and the mode routing, refusal of the test code, detection of short, long and empty frames, and recovery on the frame after an error. All of these depend on which serial sequence was sent.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int FRAME_W = 24;
  localparam int MODE_W  = 2;
  localparam int PAY_W   = FRAME_W - MODE_W;
  localparam int NUM_TGT = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_GAIN = 2'b00,
    MODE_PRIM = 2'b01,
    MODE_SEC  = 2'b10,
    MODE_TEST = 2'b11
  } mode_e;

  localparam int TGT_GAIN = 0;
  localparam int TGT_PRIM = 1;
  localparam int TGT_SEC  = 2;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfgp_shifter.sv
module cfgp_shifter #(
  parameter int FRAME_W = 24,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_s,
  input  logic               shift_s,
  input  logic               clr,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   count
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

  logic               shift_d_q;
  logic               shift_rise;
  logic [FRAME_W-1:0] sr_q, sr_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;

  assign shift_rise = shift_s & ~shift_d_q;

  always_comb begin
    sr_n  = sr_q;
    cnt_n = cnt_q;
    if (clr) begin
      sr_n  = '0;
      cnt_n = '0;
    end else if (shift_rise) begin
      sr_n = {sr_q[FRAME_W-2:0], data_s};
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_d_q <= 1'b0;
      sr_q      <= '0;
      cnt_q     <= '0;
    end else begin
      shift_d_q <= shift_s;
      sr_q      <= sr_n;
      cnt_q     <= cnt_n;
    end
  end

  assign frame = sr_q;
  assign count = cnt_q;
endmodule

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int MODE_W  = 2,
  parameter int NUM_TGT = 3,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               latch_s,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   count,
  output logic               commit,
  output logic [NUM_TGT-1:0] load,
  output logic               err
);
  logic  latch_d_q;
  logic  len_ok;
  logic  err_q, err_n;
  mode_e mode;

  assign commit = latch_s & ~latch_d_q;
  assign len_ok = (count == CNT_W'(FRAME_W));
  assign mode   = mode_e'(frame[FRAME_W-1 -: MODE_W]);

  always_comb begin
    load = '0;
    if (commit && len_ok) begin
      unique case (mode)
        MODE_GAIN: load[TGT_GAIN] = 1'b1;
        MODE_PRIM: load[TGT_PRIM] = 1'b1;
        MODE_SEC:  load[TGT_SEC]  = 1'b1;
        MODE_TEST: load = '0;
      endcase
    end
  end

  assign err_n = commit & ~len_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_d_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      latch_d_q <= latch_s;
      err_q     <= err_n;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank #(
  parameter int PAY_W   = 22,
  parameter int NUM_TGT = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_TGT-1:0]       load,
  input  logic [PAY_W-1:0]         payload,
  output logic [NUM_TGT*PAY_W-1:0] words,
  output logic [NUM_TGT-1:0]       upd
);
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic [PAY_W-1:0] word_q, word_n;
    logic             upd_q;

    always_comb begin
      word_n = word_q;
      if (load[t]) word_n = payload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        upd_q  <= 1'b0;
      end else begin
        word_q <= word_n;
        upd_q  <= load[t];
      end
    end

    assign words[t*PAY_W +: PAY_W] = word_q;
    assign upd[t] = upd_q;
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int P_FRAME_W = cfgp_pkg::FRAME_W,
  parameter int P_MODE_W  = cfgp_pkg::MODE_W,
  parameter int P_SYNC    = cfgp_pkg::SYNC_STAGES,
  localparam int P_PAY_W  = P_FRAME_W - P_MODE_W,
  localparam int P_CNT_W  = $clog2(P_FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_data,
  input  logic               cfg_shift,
  input  logic               cfg_latch,
  output logic [P_PAY_W-1:0] gain_word,
  output logic [P_PAY_W-1:0] prim_word,
  output logic [P_PAY_W-1:0] sec_word,
  output logic               upd_gain,
  output logic               upd_prim,
  output logic               upd_sec,
  output logic               frame_err,
  output logic               mclk_ratio_512
);
  localparam int RATIO_BIT = P_PAY_W - 1;

  logic [1:0]                 rst_pipe_q;
  logic                       rst_int_n;
  logic [2:0]                 pins_s;
  logic [P_FRAME_W-1:0]       frame;
  logic [P_CNT_W-1:0]         count;
  logic                       commit;
  logic [NUM_TGT-1:0]         load;
  logic [NUM_TGT*P_PAY_W-1:0] words;
  logic [NUM_TGT-1:0]         upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  cfgp_sync #(.W(3), .STAGES(P_SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({cfg_latch, cfg_shift, cfg_data}),
    .q     (pins_s)
  );

  cfgp_shifter #(.FRAME_W(P_FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .data_s  (pins_s[0]),
    .shift_s (pins_s[1]),
    .clr     (commit),
    .frame   (frame),
    .count   (count)
  );

  cfgp_decode #(.FRAME_W(P_FRAME_W), .MODE_W(P_MODE_W), .NUM_TGT(NUM_TGT)) u_dec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .latch_s (pins_s[2]),
    .frame   (frame),
    .count   (count),
    .commit  (commit),
    .load    (load),
    .err     (frame_err)
  );

  cfgp_regbank #(.PAY_W(P_PAY_W), .NUM_TGT(NUM_TGT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (load),
    .payload (frame[P_PAY_W-1:0]),
    .words   (words),
    .upd     (upd)
  );

  assign gain_word      = words[TGT_GAIN*P_PAY_W +: P_PAY_W];
  assign prim_word      = words[TGT_PRIM*P_PAY_W +: P_PAY_W];
  assign sec_word       = words[TGT_SEC*P_PAY_W +: P_PAY_W];
  assign upd_gain       = upd[TGT_GAIN];
  assign upd_prim       = upd[TGT_PRIM];
  assign upd_sec        = upd[TGT_SEC];
  assign mclk_ratio_512 = sec_word[RATIO_BIT];
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int PAY_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PAY_W-1:0] gain_word,
  input logic [PAY_W-1:0] prim_word,
  input logic [PAY_W-1:0] sec_word,
  input logic             upd_gain,
  input logic             upd_prim,
  input logic             upd_sec,
  input logic             frame_err,
  input logic             mclk_ratio_512
);
  a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_gain, upd_prim, upd_sec, frame_err}));
  a_r9_gain_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_gain |=> !upd_gain);
  a_r9_prim_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_prim |=> !upd_prim);
  a_r9_sec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_sec |=> !upd_sec);
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  a_r3_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_gain |-> $stable(gain_word));
  a_r4_prim_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_prim |-> $stable(prim_word));
  a_r5_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_sec |-> $stable(sec_word));
  a_r7_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_sec |-> $stable(mclk_ratio_512));
  a_r8_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($stable(gain_word) && $stable(prim_word) && $stable(sec_word)));
endmodule

bind cfg_serial_port cfgp_checker #(.PAY_W(P_PAY_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .gain_word      (gain_word),
  .prim_word      (prim_word),
  .sec_word       (sec_word),
  .upd_gain       (upd_gain),
  .upd_prim       (upd_prim),
  .upd_sec        (upd_sec),
  .frame_err      (frame_err),
  .mclk_ratio_512 (mclk_ratio_512)
);

// File: tb/sim_cfg_serial_port.sv
`timescale 1ns/1ps
module sim_cfg_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_data = 1'b0, cfg_shift = 1'b0, cfg_latch = 1'b0;
  logic [21:0] gain_word, prim_word, sec_word;
  logic        upd_gain, upd_prim, upd_sec, frame_err, mclk_ratio_512;

  always #5 clk = ~clk;

  cfg_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data), .cfg_shift(cfg_shift),
    .cfg_latch(cfg_latch), .gain_word(gain_word), .prim_word(prim_word),
    .sec_word(sec_word), .upd_gain(upd_gain), .upd_prim(upd_prim),
    .upd_sec(upd_sec), .frame_err(frame_err), .mclk_ratio_512(mclk_ratio_512)
  );

  typedef struct {
    logic [3:0]  ev;
    logic [21:0] g, p, s;
    string       req;
  } item_t;

  item_t       sb_q[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  logic [21:0] m_g = '0, m_p = '0, m_s = '0;
  logic [3:0]  prev_ev = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one frame: nbits bits, first-sent = bits[23] side, then a latch pulse.
  task automatic send(input logic [23:0] bits, input int nbits, input string req);
    item_t it;
    logic [23:0] sr = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      cfg_data = (i < 24) ? bits[23-i] : 1'b0;
      sr = {sr[22:0], cfg_data};
      repeat (4) @(negedge clk);
      cfg_shift = 1'b1;
      repeat (4) @(negedge clk);
      cfg_shift = 1'b0;
    end
    it.req = req;
    if (nbits != 24) it.ev = 4'b1000;
    else case (sr[23:22])
      2'b00: begin m_g = sr[21:0]; it.ev = 4'b0001; end
      2'b01: begin m_p = sr[21:0]; it.ev = 4'b0010; end
      2'b10: begin m_s = sr[21:0]; it.ev = 4'b0100; end
      default: it.ev = 4'b0000;
    endcase
    it.g = m_g; it.p = m_p; it.s = m_s;
    if (it.ev != 0) sb_q.push_back(it);
    repeat (4) @(negedge clk);
    cfg_latch = 1'b1;
    repeat (6) @(negedge clk);
    cfg_latch = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // Monitor: pop the expected item on every strobe or error pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        logic [3:0] ev;
        ev = {frame_err, upd_sec, upd_prim, upd_gain};
        if (ev != 0 && prev_ev == ev)
          chk(1'b0, "R9 pulse longer than one cycle", 32'(ev), 32'(0));
        else if (ev != 0) begin
          if (sb_q.size() == 0)
            chk(1'b0, "R6/R9 unexpected event", 32'(ev), 32'(0));
          else begin
            item_t it;
            it = sb_q.pop_front();
            chk(ev == it.ev, {it.req, " event"}, 32'(ev), 32'(it.ev));
            chk(gain_word == it.g, {it.req, " gain_word"}, 32'(gain_word), 32'(it.g));
            chk(prim_word == it.p, {it.req, " prim_word"}, 32'(prim_word), 32'(it.p));
            chk(sec_word == it.s, {it.req, " sec_word"}, 32'(sec_word), 32'(it.s));
            chk(mclk_ratio_512 == it.s[21], {it.req, " R7 ratio"}, 32'(mclk_ratio_512), 32'(it.s[21]));
          end
        end
        prev_ev = ev;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(0), 32'(1));
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(gain_word == 0 && prim_word == 0 && sec_word == 0, "R1 words zero",
        32'({gain_word[9:0], prim_word[9:0], sec_word[9:0]}), 32'(0));
    chk(mclk_ratio_512 == 1'b0, "R1 ratio 256x", 32'(mclk_ratio_512), 32'(0));
    chk({upd_gain, upd_prim, upd_sec, frame_err} == 0, "R1 no pulses",
        32'({upd_gain, upd_prim, upd_sec, frame_err}), 32'(0));

    send({2'b00, 22'h2AAAAA}, 24, "R3 R2 gain frame");
    send({2'b01, 22'h155555}, 24, "R4 prim frame");
    send({2'b10, 22'h2F00C3}, 24, "R5 R7 sec frame 512x");
    chk(mclk_ratio_512 == 1'b1, "R7 ratio 512x", 32'(mclk_ratio_512), 32'(1));

    // R6 test code refused
    send({2'b11, 22'h3FFFFF}, 24, "R6 test mode");
    chk(gain_word == m_g, "R6 gain unchanged", 32'(gain_word), 32'(m_g));
    chk(prim_word == m_p, "R6 prim unchanged", 32'(prim_word), 32'(m_p));
    chk(sec_word == m_s, "R6 sec unchanged", 32'(sec_word), 32'(m_s));

    send({2'b00, 22'h012345}, 23, "R8 short frame");
    send({2'b01, 22'h0ABCDE}, 25, "R8 long frame");
    send(24'h0, 0, "R8 empty frame");
    send({2'b00, 22'h1C3A5F}, 24, "R10 gain after error");
    send({2'b10, 22'h0F0F0F}, 24, "R7 sec frame 256x");
    chk(mclk_ratio_512 == 1'b0, "R7 ratio back to 256x", 32'(mclk_ratio_512), 32'(0));
    send({2'b01, 22'h3C0001}, 24, "R2 R4 prim edge bits");

    repeat (20) @(negedge clk);
    chk(sb_q.size() == 0, "R9 all expected events seen", 32'(sb_q.size()), 32'(0));
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule